// File: doc/BRIEF.md
# Nonvolatile image checksum engine

The engine checks or repairs the signature word of an image of 16-bit words held in nonvolatile storage. It reaches the storage through a single word request port. The port carries a request, a write flag, an address and write data. The storage answers each request with an acknowledge, read data and an error flag. The storage protocol and any retry policy sit behind that port and belong to the neighbour.

A start pulse launches one operation, and the mode input sampled with it picks the kind.

- **Check mode** adds every word from address 0 through the signature address, modulo 2^16. It then reports whether the total equals the fixed value 0xBABA.
- **Fix mode** adds only the words below the signature address. It then writes the compensating word that brings the total to 0xBABA.

Each operation ends with a one-cycle completion pulse. Two flags travel with the pulse: a pass flag and a transfer-error flag.

Top module: `nvm_csum_engine`

## Requirements
- R1: After reset, done_o, valid_o, error_o and req_o are all low and stay low until a start is given.
- R2: Reads are issued one at a time, in ascending address order, starting at address 0. Each request (req_o=1, we_o=0) keeps its address until the cycle in which ack_i is high.
- R3: In check mode (mode_i=0 at start), every word at addresses 0..CSUM_ADDR is read. If the 16-bit wraparound sum equals 0xBABA, done_o pulses with valid_o=1 and error_o=0.
- R4: A check-mode sum other than 0xBABA gives done_o=1 with valid_o=0 and error_o=0. This mismatch result is distinct from both a pass and a transfer error.
- R5: In fix mode (mode_i=1 at start), addresses 0..CSUM_ADDR-1 are read. Then a single write (we_o=1) goes to CSUM_ADDR with wdata_o = (0xBABA - sum) mod 2^16. A write acknowledged without error gives done_o with valid_o=1.
- R6: A read acknowledged with err_i=1 aborts the operation: no further request is issued, and done_o pulses with error_o=1 and valid_o=0.
- R7: A fix-mode write acknowledged with err_i=1 gives done_o with error_o=1 and valid_o=0.
- R8: done_o is high for exactly one cycle. That cycle follows the clock edge that takes the final acknowledge. valid_o and error_o are high only in that cycle.
- R9: start_i is ignored while an operation is in progress. The request sequence continues unchanged and no extra completion occurs.
- R10: The mode is captured only at start. Changing mode_i during an operation has no effect on the requests or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch an operation when idle |
| mode_i | input | 1 | 0 = check, 1 = fix; sampled with start |
| req_o | output | 1 | Word request to storage |
| we_o | output | 1 | Request is a write |
| addr_o | output | ADDR_W | Word address of the request |
| wdata_o | output | 16 | Write data (compensating word) |
| ack_i | input | 1 | Storage completed the request this cycle |
| err_i | input | 1 | Completed request failed (valid with ack_i) |
| rdata_i | input | 16 | Read data (valid with ack_i) |
| done_o | output | 1 | One-cycle completion pulse |
| valid_o | output | 1 | With done: checksum matched or write succeeded |
| error_o | output | 1 | With done: a read or write failed |

## Verification
The bench uses words large enough to overflow 16 bits, so an engine that widened or saturated the sum would report a false pass or write a wrong compensating word. Read errors are injected at the first word, in the middle, and at the signature word itself. An engine that kept reading, or that flagged a pass, would issue an extra request or raise valid_o. A failed write is followed by a check pass. A design that counted the failed write as a success would pass the check, although the storage still holds the old word. Starts and mode flips are also driven while requests are stalled. A design that restarted would jump back to address 0, and one that resampled the mode would skip or add the write.

// File: rtl/nvm_csum_pkg.sv
package nvm_csum_pkg;
  localparam int unsigned WORD_W = 16;
  localparam logic [WORD_W-1:0] CSUM_SIG = 16'hBABA;

  typedef enum logic {
    MODE_CHECK = 1'b0,
    MODE_FIX   = 1'b1
  } csum_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } csum_state_e;
endpackage

// File: rtl/nvm_csum_acc.sv
module nvm_csum_acc #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         add_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] sum_q;

  // modulo 2^W: carry out is dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sum_q <= '0;
    else if (clr_i) sum_q <= '0;
    else if (add_i) sum_q <= sum_q + din_i;
  end

  assign sum_o = sum_q;
endmodule

// File: rtl/nvm_csum_ctrl.sv
module nvm_csum_ctrl
  import nvm_csum_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned CSUM_ADDR = 63
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic              ack_i,
  input  logic              err_i,
  input  logic              match_i,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              acc_clr_o,
  output logic              acc_add_o,
  output logic              done_o,
  output logic              valid_o,
  output logic              error_o
);
  localparam logic [ADDR_W-1:0] SIG_ADDR  = ADDR_W'(CSUM_ADDR);
  localparam logic [ADDR_W-1:0] LAST_FIX  = ADDR_W'((CSUM_ADDR == 0) ? 0 : CSUM_ADDR - 1);
  localparam bit                FIX_EMPTY = (CSUM_ADDR == 0);

  csum_state_e       state_q;
  csum_mode_e        mode_q;
  logic [ADDR_W-1:0] addr_q;
  logic              done_q, valid_q, error_q;
  logic              last_rd;

  assign last_rd   = (mode_q == MODE_FIX) ? (addr_q == LAST_FIX) : (addr_q == SIG_ADDR);
  assign acc_clr_o = (state_q == ST_IDLE) && start_i;
  assign acc_add_o = (state_q == ST_READ) && ack_i && !err_i;
  assign req_o     = (state_q != ST_IDLE);
  assign we_o      = (state_q == ST_WRITE);
  assign addr_o    = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_CHECK;
      addr_q  <= '0;
      done_q  <= 1'b0;
      valid_q <= 1'b0;
      error_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      valid_q <= 1'b0;
      error_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          mode_q <= csum_mode_e'(mode_i);
          if (mode_i && FIX_EMPTY) begin
            addr_q  <= SIG_ADDR;
            state_q <= ST_WRITE;
          end else begin
            addr_q  <= '0;
            state_q <= ST_READ;
          end
        end
        ST_READ: if (ack_i) begin
          if (err_i) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            error_q <= 1'b1;
          end else if (last_rd) begin
            if (mode_q == MODE_CHECK) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              valid_q <= match_i;
            end else begin
              addr_q  <= SIG_ADDR;
              state_q <= ST_WRITE;
            end
          end else begin
            addr_q <= addr_q + 1'b1;
          end
        end
        ST_WRITE: if (ack_i) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          valid_q <= !err_i;
          error_q <= err_i;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o  = done_q;
  assign valid_o = valid_q;
  assign error_o = error_q;
endmodule

// File: rtl/nvm_csum_engine.sv
module nvm_csum_engine
  import nvm_csum_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned CSUM_ADDR = 63
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mode_i,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [WORD_W-1:0] wdata_o,
  input  logic              ack_i,
  input  logic              err_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic              done_o,
  output logic              valid_o,
  output logic              error_o
);
  logic              acc_clr, acc_add, match;
  logic [WORD_W-1:0] sum;

  nvm_csum_acc #(.W(WORD_W)) i_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (acc_clr),
    .add_i  (acc_add),
    .din_i  (rdata_i),
    .sum_o  (sum)
  );

  // the signature word arrives with the last ack; fold it in combinationally
  assign match   = ((sum + rdata_i) == CSUM_SIG);
  assign wdata_o = CSUM_SIG - sum;

  nvm_csum_ctrl #(.ADDR_W(ADDR_W), .CSUM_ADDR(CSUM_ADDR)) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .mode_i    (mode_i),
    .ack_i     (ack_i),
    .err_i     (err_i),
    .match_i   (match),
    .req_o     (req_o),
    .we_o      (we_o),
    .addr_o    (addr_o),
    .acc_clr_o (acc_clr),
    .acc_add_o (acc_add),
    .done_o    (done_o),
    .valid_o   (valid_o),
    .error_o   (error_o)
  );
endmodule

// File: rtl/nvm_csum_chk.sv
module nvm_csum_chk #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned CSUM_ADDR = 63
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_o,
  input logic              we_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              ack_i,
  input logic              err_i,
  input logic              done_o,
  input logic              valid_o,
  input logic              error_o
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_FLAGS_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o || error_o) |-> done_o); // R8
  AST_PASS_XOR_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && error_o)); // R4
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> (req_o && $stable(addr_o) && $stable(we_o))); // R2
  AST_READ_ASCEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !we_o && ack_i && !err_i) |=>
      (!req_o || we_o || (addr_o == ADDR_W'($past(addr_o) + 1'b1)))); // R2
  AST_WRITE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && we_o) |-> (addr_o == ADDR_W'(CSUM_ADDR))); // R5
  AST_ERR_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && ack_i && err_i) |=> (!req_o && done_o && error_o)); // R6
  AST_IDLE_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !req_o); // R9
endmodule

bind nvm_csum_engine nvm_csum_chk #(.ADDR_W(ADDR_W), .CSUM_ADDR(CSUM_ADDR)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_o   (req_o),
  .we_o    (we_o),
  .addr_o  (addr_o),
  .ack_i   (ack_i),
  .err_i   (err_i),
  .done_o  (done_o),
  .valid_o (valid_o),
  .error_o (error_o)
);

// File: tb/test_nvm_csum_engine.sv
module test_nvm_csum_engine;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned C      = 63;
  localparam logic [15:0] SIG    = 16'hBABA;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, mode = 1'b0, ack = 1'b0, err = 1'b0;
  logic [15:0] rdata = '0;
  logic req, we, done, valid, error;
  logic [ADDR_W-1:0] addr;
  logic [15:0] wdata;

  int errors = 0, checks = 0;
  logic [15:0] mem [0:C];

  always #4 clk = ~clk;

  nvm_csum_engine #(.ADDR_W(ADDR_W), .CSUM_ADDR(C)) i_nvm_csum_engine (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .req_o(req), .we_o(we), .addr_o(addr), .wdata_o(wdata),
    .ack_i(ack), .err_i(err), .rdata_i(rdata),
    .done_o(done), .valid_o(valid), .error_o(error)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // expects a live request of the given kind on every cycle of the stall
  task automatic serve(input string r, input bit wr, input int a, input logic [15:0] wd,
                       input int lat, input bit poke, input bit upd, input bit e);
    for (int w = 0; w < lat; w++) begin
      chk({r, " req held"}, {req, we, 8'(addr)}, {1'b1, wr, 8'(a)});
      chk("R8 no early done", done, 0);
      if (poke) begin start = 1'b1; mode = ~upd; end
      @(negedge clk);
    end
    chk({r, " req"}, {req, we, 8'(addr)}, {1'b1, wr, 8'(a)});
    if (wr) chk("R5 wdata", wdata, wd);
    start = 1'b0; mode = upd;
    ack = 1'b1; err = e; rdata = wr ? 16'h0 : mem[a];
    @(negedge clk);
    ack = 1'b0; err = 1'b0;
  endtask

  task automatic finish_chk(input string r, input bit v, input bit e);
    chk({r, " done"}, {done, valid, error, req}, {1'b1, v, e, 1'b0});
    @(negedge clk);
    chk("R8 pulse ends", {done, valid, error, req}, 4'b0000);
  endtask

  task automatic do_op(input bit upd, input int err_idx, input bit werr,
                       input int lat, input bit poke);
    logic [15:0] sum = '0;
    int n = upd ? C : C + 1;
    @(negedge clk);
    start = 1'b1; mode = upd;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < n; k++) begin
      serve("R2", 1'b0, k, 16'h0, lat, poke, upd, k == err_idx);
      if (k == err_idx) begin
        finish_chk("R6", 1'b0, 1'b1);
        return;
      end
      sum += mem[k];
    end
    if (!upd) begin
      finish_chk((sum == SIG) ? "R3" : "R4", sum == SIG, 1'b0);
    end else begin
      serve("R5", 1'b1, C, SIG - sum, lat, poke, upd, werr);
      if (!werr) mem[C] = SIG - sum;
      finish_chk(werr ? "R7" : "R5", !werr, werr);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", {done, valid, error, req}, 4'b0000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle", {done, valid, error, req}, 4'b0000);

    for (int i = 0; i <= C; i++) mem[i] = 16'(i * 16'h1357) ^ 16'hA5C3;
    do_op(1'b1, -1, 1'b0, 0, 1'b0);   // R5 fix
    do_op(1'b0, -1, 1'b0, 2, 1'b1);   // R3 pass with starts/mode flips while busy: R9 R10
    mem[5] ^= 16'h0100;
    do_op(1'b0, -1, 1'b0, 1, 1'b0);   // R4 mismatch
    do_op(1'b0, 0, 1'b0, 0, 1'b0);    // R6 error at first read
    do_op(1'b1, 17, 1'b0, 1, 1'b1);   // R6 error mid fix
    do_op(1'b1, -1, 1'b1, 0, 1'b0);   // R7 write failure
    do_op(1'b0, -1, 1'b0, 0, 1'b0);   // R4 image still bad after failed write
    do_op(1'b0, C, 1'b0, 0, 1'b0);    // R6 error on signature word
    for (int i = 0; i <= C; i++) mem[i] = 16'hF00D;
    do_op(1'b0, -1, 1'b0, 0, 1'b0);   // R4 wrapped sum mismatch
    do_op(1'b1, -1, 1'b0, 1, 1'b0);   // R5 wrapped fix
    do_op(1'b0, -1, 1'b0, 0, 1'b0);   // R3 wrapped pass
    repeat (3) @(negedge clk);
    chk("R9 stays idle", {done, req}, 2'b00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule